// File: doc/BRIEF.md
# Multi-Drop Serial Configuration Port for a Two-Channel Transcoder

This block is the write-only configuration slave of a two-channel voice transcoder. A host shares one three-wire bus (serial clock, active-low select, serial data) among many such devices. Each device answers only to frames whose leading command byte carries its six-bit strapped address. The command byte also names one of two channels, X or Y. The bytes that follow load that channel's control byte and, when the frame is long enough, its input and output time-slot numbers. The block keeps one register set per channel. It brings both sets out to the processing engine as plain levels, with a one-cycle update strobe for each channel. It also asks the engine to float the addressed channel's data outputs while a matching frame is open.

All three bus wires are oversampled in the engine clock domain through synchronisers, so the whole block runs on one clock. A new frame takes effect only when select returns high; a frame cut short leaves the registers alone. The engine pulses a per-channel done input when an algorithm reset it was asked for has finished, and the block then clears the request bit. When the mode strap is low, the serial port is dead. The control outputs then follow strap pins, and the time slots read zero.

Top module: `cfg_serial_port`

## Requirements
- R1: A bit is taken on each rising edge of `sclk` while `cs_n` is low, and bytes arrive least significant bit first. Clock edges while `cs_n` is high change no register and raise no strobe.
- R2: The first byte of a frame is the command byte. The frame is accepted only if bits 5..0 equal `dev_addr` and bit 7 is 0. Any other command byte leaves both register sets unchanged, gives no strobe and raises no float request.
- R3: Command bit 6 picks the channel: 1 loads channel X and 0 loads channel Y. The other channel's registers do not change.
- R4: Byte 1 is the control byte. An accepted frame of 2 or 3 whole bytes loads only the control byte. With 4 or more whole bytes, byte 2 bits 5..0 also load the input slot and byte 3 bits 5..0 load the output slot. Bytes after the fourth are ignored.
- R5: A frame whose select returns high before 2 whole bytes have arrived changes nothing. Any trailing partial byte is dropped.
- R6: After reset, both control bytes read 0x20 (only the idle bit 5 set), all slots read 0, and no strobe or float request is high.
- R7: Control bit 4 is the algorithm-reset request. A one-cycle pulse on that channel's `alrst_done` bit clears bit 4 and leaves the other control bits as they were.
- R8: `float_req` for the addressed channel goes high once an accepted command byte has been received. It stays high until `cs_n` returns high. It stays low for all other frames and for the other channel.
- R9: Each accepted frame gives exactly one single-cycle pulse on that channel's `upd` bit. The pulse comes in the first cycle in which the new values appear on the outputs.
- R10: With `sw_mode` low, the serial port is ignored, all slots read 0 and no strobe or float request is raised. Control X then reads bit 5 = `cs_n`, bit 2 = `dev_addr[2]`, bit 0 = `dev_addr[0]`, and control Y reads bit 5 = `sdi`, bit 2 = `dev_addr[5]`, bit 0 = `dev_addr[3]`. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode | input | 1 | Mode strap: 1 serial configuration, 0 strap-pin configuration |
| dev_addr | input | 6 | Strapped device address; in strap mode, source of coding and format bits |
| sclk | input | 1 | Serial bus clock from the host |
| cs_n | input | 1 | Active-low frame select; in strap mode, X idle bit |
| sdi | input | 1 | Serial data; in strap mode, Y idle bit |
| alrst_done | input | 2 | Per-channel algorithm-reset done pulse (bit 0 X, bit 1 Y) |
| ctrl_x | output | 8 | Channel X control byte |
| in_slot_x | output | 6 | Channel X input time slot |
| out_slot_x | output | 6 | Channel X output time slot |
| ctrl_y | output | 8 | Channel Y control byte |
| in_slot_y | output | 6 | Channel Y input time slot |
| out_slot_y | output | 6 | Channel Y output time slot |
| upd | output | 2 | Per-channel one-cycle update strobe (bit 0 X, bit 1 Y) |
| float_req | output | 2 | Per-channel request to float data outputs (bit 0 X, bit 1 Y) |

## Verification
The bench uses the default build: a six-bit address, six-bit slots and two synchroniser stages. With those widths it can try every address value, with the reserved bit both clear and set, against one fixed strap. It can also walk all 256 combinations of address pins, select and data in strap mode. It varies frame length across whole and partial byte counts on both channels. It checks every output against a register model kept in the bench.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 6;
  localparam int NUM_CH     = 2;
  localparam int CHSEL_BIT  = 6;
  localparam int RSVD_BIT   = 7;
  localparam int IPD_BIT    = 5;
  localparam int ALRST_BIT  = 4;
  localparam int UA_BIT     = 2;
  localparam int CPEX_BIT   = 0;
  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h20;
  localparam int MAX_BYTES  = 4;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_slots;
    logic is_x;
  } commit_t;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgp_deframer.sv
module cfgp_deframer
  import cfgp_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output commit_t           cm,
  output logic [BYTE_W-1:0] ctrl_st,
  output logic [SLOT_W-1:0] in_st,
  output logic [SLOT_W-1:0] out_st,
  output logic              hit,
  output logic              is_x
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int BYTE_CW = $clog2(MAX_BYTES + 1);
  localparam logic [BYTE_CW-1:0] LAST_BYTE = BYTE_CW'(MAX_BYTES);

  logic              sclk_q, cs_q;
  logic [BYTE_W-1:0] sh;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_CW-1:0] byte_cnt;
  logic [BYTE_W-1:0] byte_v;
  logic              rise, frame_end, addr_ok;

  assign rise      = sclk_s & ~sclk_q;
  assign frame_end = en & cs_n_s & ~cs_q;
  assign byte_v    = {sdi_s, sh[BYTE_W-1:1]};
  assign addr_ok   = (byte_v[ADDR_W-1:0] == dev_addr) && !byte_v[RSVD_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh       <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      hit      <= 1'b0;
      is_x     <= 1'b0;
      ctrl_st  <= '0;
      in_st    <= '0;
      out_st   <= '0;
    end else if (!en || cs_n_s) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      hit      <= 1'b0;
    end else if (rise) begin
      sh      <= byte_v;
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == BIT_CW'(BYTE_W - 1)) begin
        case (byte_cnt)
          BYTE_CW'(0): begin
            hit  <= addr_ok;
            is_x <= byte_v[CHSEL_BIT];
          end
          BYTE_CW'(1): ctrl_st <= byte_v;
          BYTE_CW'(2): in_st   <= byte_v[SLOT_W-1:0];
          BYTE_CW'(3): out_st  <= byte_v[SLOT_W-1:0];
          default: ;
        endcase
        if (byte_cnt != LAST_BYTE) byte_cnt <= byte_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cm <= '0;
    else begin
      cm.wr_ctrl  <= frame_end & hit & (byte_cnt >= BYTE_CW'(2));
      cm.wr_slots <= frame_end & hit & (byte_cnt == LAST_BYTE);
      cm.is_x     <= is_x;
    end

  assert_byte_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= LAST_BYTE);
  assert_hit_drops_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cs_n_s) |=> !hit);
  assert_commit_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cm.wr_ctrl |-> $past(hit));
  assert_idle_when_strapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hit && !cm.wr_ctrl));
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_slots,
  input  logic [BYTE_W-1:0] ctrl_d,
  input  logic [SLOT_W-1:0] in_d,
  input  logic [SLOT_W-1:0] out_d,
  input  logic              alrst_done,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [SLOT_W-1:0] in_q,
  output logic [SLOT_W-1:0] out_q,
  output logic              upd
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      in_q   <= '0;
      out_q  <= '0;
      upd    <= 1'b0;
    end else begin
      upd <= wr_ctrl;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      else if (alrst_done) ctrl_q[ALRST_BIT] <= 1'b0;
      if (wr_slots) begin
        in_q  <= in_d;
        out_q <= out_d;
      end
    end

  assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  assert_alrst_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alrst_done && !wr_ctrl && ctrl_q[ALRST_BIT]) |=> !ctrl_q[ALRST_BIT]);
  assert_slots_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slots |=> ($stable(in_q) && $stable(out_q)));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_mode,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [NUM_CH-1:0] alrst_done,
  output logic [BYTE_W-1:0] ctrl_x,
  output logic [SLOT_W-1:0] in_slot_x,
  output logic [SLOT_W-1:0] out_slot_x,
  output logic [BYTE_W-1:0] ctrl_y,
  output logic [SLOT_W-1:0] in_slot_y,
  output logic [SLOT_W-1:0] out_slot_y,
  output logic [NUM_CH-1:0] upd,
  output logic [NUM_CH-1:0] float_req
);
  logic              sclk_s, cs_n_s, sdi_s;
  commit_t           cm;
  logic [BYTE_W-1:0] ctrl_st;
  logic [SLOT_W-1:0] in_st, out_st;
  logic              hit, is_x;
  logic [BYTE_W-1:0] bank_ctrl [NUM_CH];
  logic [SLOT_W-1:0] bank_in   [NUM_CH];
  logic [SLOT_W-1:0] bank_out  [NUM_CH];
  logic [NUM_CH-1:0] bank_upd;
  logic [BYTE_W-1:0] hw_x, hw_y;

  cfgp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, sdi}), .q({sclk_s, cs_n_s, sdi_s})
  );

  cfgp_deframer #(.SLOT_W(SLOT_W)) u_deframer (
    .clk(clk), .rst_n(rst_n), .en(sw_mode), .dev_addr(dev_addr),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .cm(cm), .ctrl_st(ctrl_st), .in_st(in_st), .out_st(out_st),
    .hit(hit), .is_x(is_x)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic SEL_X = (c == 0);
    logic ch_sel;
    assign ch_sel = (cm.is_x == SEL_X);
    cfgp_bank #(.SLOT_W(SLOT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(cm.wr_ctrl & ch_sel), .wr_slots(cm.wr_slots & ch_sel),
      .ctrl_d(ctrl_st), .in_d(in_st), .out_d(out_st),
      .alrst_done(alrst_done[c]),
      .ctrl_q(bank_ctrl[c]), .in_q(bank_in[c]), .out_q(bank_out[c]),
      .upd(bank_upd[c])
    );
    assign float_req[c] = sw_mode & hit & (is_x == SEL_X);
  end

  always_comb begin
    hw_x = '0;
    hw_x[IPD_BIT]  = cs_n_s;
    hw_x[UA_BIT]   = dev_addr[2];
    hw_x[CPEX_BIT] = dev_addr[0];
    hw_y = '0;
    hw_y[IPD_BIT]  = sdi_s;
    hw_y[UA_BIT]   = dev_addr[5];
    hw_y[CPEX_BIT] = dev_addr[3];
  end

  assign ctrl_x     = sw_mode ? bank_ctrl[0] : hw_x;
  assign ctrl_y     = sw_mode ? bank_ctrl[1] : hw_y;
  assign in_slot_x  = sw_mode ? bank_in[0]   : '0;
  assign out_slot_x = sw_mode ? bank_out[0]  : '0;
  assign in_slot_y  = sw_mode ? bank_in[1]   : '0;
  assign out_slot_y = sw_mode ? bank_out[1]  : '0;
  assign upd        = sw_mode ? bank_upd     : '0;

  assert_one_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(float_req));
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam int HALF = 4;
  logic clk = 0, rst_n = 0, sw_mode = 1;
  logic [5:0] dev_addr = 6'h2A;
  logic sclk = 0, cs_n = 1, sdi = 0;
  logic [1:0] alrst_done = 0;
  logic [7:0] ctrl_x, ctrl_y;
  logic [5:0] in_slot_x, out_slot_x, in_slot_y, out_slot_y;
  logic [1:0] upd, float_req;

  int checks = 0, errors = 0, nupd_x = 0, nupd_y = 0;
  bit done = 0;
  logic [7:0] ex_ctrl [2];
  logic [5:0] ex_in [2], ex_out [2];
  logic [1:0] fl_mid;

  always #2 clk = ~clk;

  cfg_serial_port dut (.clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .dev_addr(dev_addr),
    .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .alrst_done(alrst_done),
    .ctrl_x(ctrl_x), .in_slot_x(in_slot_x), .out_slot_x(out_slot_x),
    .ctrl_y(ctrl_y), .in_slot_y(in_slot_y), .out_slot_y(out_slot_y),
    .upd(upd), .float_req(float_req));

  always @(posedge clk) begin
    if (upd[0]) nupd_x++;
    if (upd[1]) nupd_y++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [39:0] d, input int nbits);
    @(negedge clk); cs_n = 0; wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = d[i]; wait_clk(HALF);
      sclk = 1; wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(6);
    fl_mid = float_req;
    cs_n = 1;
    wait_clk(10);
  endtask

  task automatic compare(input string req);
    chk(ctrl_x == ex_ctrl[0], req, ctrl_x, ex_ctrl[0]);
    chk(ctrl_y == ex_ctrl[1], req, ctrl_y, ex_ctrl[1]);
    chk(in_slot_x == ex_in[0] && out_slot_x == ex_out[0], req,
        {in_slot_x, out_slot_x}, {ex_in[0], ex_out[0]});
    chk(in_slot_y == ex_in[1] && out_slot_y == ex_out[1], req,
        {in_slot_y, out_slot_y}, {ex_in[1], ex_out[1]});
  endtask

  // Send a frame and update the model: nbytes whole bytes decide the commit.
  task automatic frame(input logic [39:0] d, input int nbits, input string req);
    int nb, ch, ex_ux, ex_uy;
    bit ok;
    nb = nbits / 8;
    ok = (nb >= 1) && (d[5:0] == dev_addr) && !d[7];
    ch = d[6] ? 0 : 1;
    nupd_x = 0; nupd_y = 0;
    send(d, nbits);
    ex_ux = 0; ex_uy = 0;
    if (ok && nb >= 2) begin
      ex_ctrl[ch] = d[15:8];
      if (ch == 0) ex_ux = 1; else ex_uy = 1;
      if (nb >= 4) begin
        ex_in[ch]  = d[21:16];
        ex_out[ch] = d[29:24];
      end
    end
    compare(req);
    chk(nupd_x == ex_ux && nupd_y == ex_uy, {req, " R9 strobe"}, {nupd_x, nupd_y}, {ex_ux, ex_uy});
    if (nb >= 1) begin
      logic [1:0] ef;
      ef = ok ? (ch == 0 ? 2'b01 : 2'b10) : 2'b00;
      chk(fl_mid == ef, {req, " R8 float"}, fl_mid, ef);
    end
    chk(float_req == 2'b00, "R8 float after end", float_req, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin ex_ctrl[c] = 8'h20; ex_in[c] = 0; ex_out[c] = 0; end
    wait_clk(5); rst_n = 1; wait_clk(5);

    // R6 reset state
    compare("R6");
    chk(upd == 0 && float_req == 0, "R6 strobes", {upd, float_req}, 0);

    // R2 address sweep with reserved bit clear and set
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 64; a++)
        frame({24'h0, (a[5:0] ^ 6'h15), 2'b00, r[0], 1'b1, a[5:0]}, 16, "R2");

    // R3 channel Y only
    frame({24'h0, 8'h8E, 8'h2A}, 16, "R3");

    // R4/R5 frame lengths on both channels, including partial bytes
    for (int ch = 0; ch < 2; ch++) begin
      int lens[9] = '{7, 8, 12, 15, 16, 20, 24, 31, 40};
      for (int k = 0; k < 9; k++) begin
        logic [7:0] cmd;
        cmd = {1'b0, ch == 0, 6'h2A};
        frame({8'h3F, 2'b00, 6'(k + 40), 2'b00, 6'(k + 3), 8'(k * 17 + ch), cmd},
              lens[k], (lens[k] < 16) ? "R5" : "R4");
      end
    end

    // R1 clock edges with select high change nothing
    nupd_x = 0; nupd_y = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); sdi = i[0]; wait_clk(HALF); sclk = 1; wait_clk(HALF); sclk = 0;
    end
    wait_clk(8);
    compare("R1");
    chk(nupd_x == 0 && nupd_y == 0, "R1 no strobe", nupd_x + nupd_y, 0);
    frame({8'h0, 8'h05, 8'h09, 8'hA6, 8'h6A}, 32, "R1 lsb first");

    // R7 algorithm reset clear
    frame({24'h0, 8'hD9, 8'h6A}, 16, "R7 setup");
    frame({24'h0, 8'h17, 8'h2A}, 16, "R7 setup");
    @(negedge clk); alrst_done = 2'b01; @(negedge clk); alrst_done = 0; wait_clk(2);
    ex_ctrl[0] = 8'hC9;
    compare("R7 X cleared");
    @(negedge clk); alrst_done = 2'b10; @(negedge clk); alrst_done = 0; wait_clk(2);
    ex_ctrl[1] = 8'h07;
    compare("R7 Y cleared");
    @(negedge clk); alrst_done = 2'b11; @(negedge clk); alrst_done = 0; wait_clk(2);
    compare("R7 no effect when clear");

    // R10 strap mode sweep
    @(negedge clk); sw_mode = 0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] ex, ey;
      @(negedge clk); dev_addr = v[5:0]; cs_n = v[6]; sdi = v[7];
      wait_clk(5);
      ex = {2'b00, v[6], 2'b00, v[2], 1'b0, v[0]};
      ey = {2'b00, v[7], 2'b00, v[5], 1'b0, v[3]};
      chk(ctrl_x == ex, "R10 ctrl_x", ctrl_x, ex);
      chk(ctrl_y == ey, "R10 ctrl_y", ctrl_y, ey);
      chk({in_slot_x, out_slot_x, in_slot_y, out_slot_y} == 0, "R10 slots",
          {in_slot_x, out_slot_x, in_slot_y, out_slot_y}, 0);
    end
    dev_addr = 6'h2A; cs_n = 1; sdi = 0; wait_clk(5);
    nupd_x = 0; nupd_y = 0;
    send({8'h0, 8'h01, 8'h02, 8'h11, 8'h6A}, 32);
    chk(nupd_x == 0 && nupd_y == 0, "R10 no strobe", nupd_x + nupd_y, 0);
    chk(fl_mid == 0, "R10 no float", fl_mid, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule